// File: doc/BRIEF.md
# Serial Memory Read Engine

This block is the target-side read path of a two-wire serial memory that holds 256 bytes. It watches the clock and data lines through a synchroniser and finds START and STOP conditions and bit edges. It recognises its own seven-bit device address. On a read it fetches bytes from a byte array through a synchronous read port and shifts them out on the data line. It drives the data line only by pulling it low, through an open-drain enable.

A byte address counter is kept between transactions. Every byte fetched advances it by one, and it wraps from the top of the array to zero. Three reads are supported:
- A current-address read, which starts at the counter.
- A random read. The controller sends a write header and a byte address, which the engine acknowledges and loads into the counter. The controller then sends a repeated START and a read header.
- A sequential read. Each acknowledge from the controller fetches the following byte.

Data bytes that follow the address in a write belong to a separate write path. This engine neither acknowledges them nor acts on them.

The array port is synchronous: `mem_rdata` is valid in the cycle after `mem_rd_en`. The system clock must run at least 8 times faster than the bus clock.

Top module: `i2c_mem_reader`

## Requirements
- R1: After reset, `sda_oe` and `mem_rd_en` are 0 and the address counter is 0, so the first current-address read returns the byte at address 0.
- R2: START (data falling while clock high) and STOP (data rising while clock high) are recognised in any state. A START, even in the middle of a byte, restarts reception of a device address header.
- R3: When the first seven header bits (MSB first) equal `DEV_ADDR`, the engine pulls the data line low during the ninth clock. On a mismatch it never drives the line until the next START.
- R4: A read header with the eighth bit at 1 returns the byte at the counter, and the counter then holds that address plus one.
- R5: A write header (eighth bit 0) followed by a byte address gets an acknowledge on that byte, and the counter is loaded with it, even if a STOP follows at once. A random read after a repeated START returns the byte at that address.
- R6: When the controller acknowledges (data low in the ninth clock) after a data byte, the next byte, from the incremented address, is sent.
- R7: The counter wraps from 255 to 0, and a sequential read continues through the wrap.
- R8: When the controller does not acknowledge (data high in the ninth clock), the engine releases the line and issues no further array reads or drive until a START.
- R9: Data bytes are sent MSB first. `sda_oe` changes only while the clock line is low.
- R10: The engine releases the data line during the acknowledge slot of every byte it sends.
- R11: Data bytes after the byte address in a write are not acknowledged and leave the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the bus clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad (wired-AND value) |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| mem_rd_en | output | 1 | One-cycle read strobe to the byte array |
| mem_addr | output | ADDR_W | Array address for the read strobe |
| mem_rdata | input | 8 | Array data, valid the cycle after `mem_rd_en` |

## Verification
The hardest states to reach from the ports are those where one counter has to carry across several transactions and across the wrap. One example is a read that starts at 250 and runs past 255 for more than a whole array length. Another is an address-only write that ends in STOP before any data byte, followed by a plain current-address read. The stimulus covers these with directed sequences. It then runs a seeded random mix of current-address reads, random reads of random length and address-only writes, and a bench model of the counter predicts every returned byte. Aborted headers, foreign addresses and clocks sent after a NACK are driven directly. Each is followed by a read that shows the counter was left alone.

// File: rtl/smr_pkg.sv
package smr_pkg;
   localparam int BYTE_BITS = 8;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEVADR,
      ST_ACK_DEV,
      ST_WORD,
      ST_ACK_WORD,
      ST_TX,
      ST_ACK_MST,
      ST_IGNORE
   } smr_state_e;
endpackage

// File: rtl/smr_line_sync.sv
module smr_line_sync #(
   parameter int STAGES   = 2,
   parameter bit IDLE_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic lvl,
   output logic rise,
   output logic fall
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("smr_line_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;
   logic              prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= {STAGES{IDLE_VAL}};
         prev  <= IDLE_VAL;
      end else begin
         chain <= {chain[STAGES-2:0], d};
         prev  <= chain[STAGES-1];
      end
   end

   assign lvl  = chain[STAGES-1];
   assign rise = lvl & ~prev;
   assign fall = ~lvl & prev;
endmodule

// File: rtl/smr_addr_ctr.sv
module smr_addr_ctr #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         inc,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= load_val;
      else if (inc)  q <= q + 1'b1;
   end
endmodule

// File: rtl/smr_tx_shifter.sv
module smr_tx_shifter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         shift,
   output logic         msb
);
   logic [W-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sh <= '1;
      else if (load)  sh <= load_val;
      else if (shift) sh <= {sh[W-2:0], 1'b1};
   end

   assign msb = sh[W-1];
endmodule

// File: rtl/i2c_mem_reader.sv
module i2c_mem_reader
   import smr_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h50,
   parameter int         ADDR_W      = 8,
   parameter int         SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              sda_oe,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [7:0]        mem_rdata
);
   localparam int CNT_W = $clog2(BYTE_BITS + 1);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS);

   generate
      if (ADDR_W < 1 || ADDR_W > BYTE_BITS) begin : g_bad_addr
         $error("i2c_mem_reader: ADDR_W must be 1..8 for one-byte addressing");
      end
   endgenerate

   logic scl_s, scl_rise, scl_fall;
   logic sda_s, sda_rise, sda_fall;

   smr_line_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .d(scl_in),
      .lvl(scl_s), .rise(scl_rise), .fall(scl_fall));

   smr_line_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .d(sda_in),
      .lvl(sda_s), .rise(sda_rise), .fall(sda_fall));

   logic start_c, stop_c, ev_rise, ev_fall;
   assign start_c = sda_fall & scl_s;
   assign stop_c  = sda_rise & scl_s;
   assign ev_rise = scl_rise & ~start_c & ~stop_c;
   assign ev_fall = scl_fall & ~start_c & ~stop_c;

   smr_state_e     state;
   logic [CNT_W-1:0] cnt;
   logic [7:0]     rx_sh;
   logic           rw;
   logic           ack_ok;
   logic           rd_pend;
   logic [7:0]     rd_buf;
   logic           addr_hit;
   logic           byte_done;

   assign addr_hit  = (rx_sh[7:1] == DEV_ADDR);
   assign byte_done = ev_fall && (cnt == LAST_BIT);

   logic              rd_req, word_load, tx_load, tx_shift, tx_msb;
   logic [ADDR_W-1:0] ctr_q, word_val;

   assign rd_req = (state == ST_DEVADR && byte_done && addr_hit && rx_sh[0])
                || (state == ST_ACK_MST && ev_rise && !sda_s);
   assign word_load = (state == ST_WORD) && byte_done;
   assign tx_load   = ev_fall && cnt == CNT_W'(1)
                   && ((state == ST_ACK_DEV && rw) || (state == ST_ACK_MST && ack_ok));
   assign tx_shift  = (state == ST_TX) && ev_fall && (cnt != LAST_BIT);

   generate
      if (ADDR_W == BYTE_BITS) begin : g_full_word
         assign word_val = rx_sh;
      end else begin : g_part_word
         assign word_val = rx_sh[ADDR_W-1:0];
      end
   endgenerate

   smr_addr_ctr #(.W(ADDR_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .load(word_load), .load_val(word_val),
      .inc(rd_req), .q(ctr_q));

   smr_tx_shifter #(.W(BYTE_BITS)) u_tx (
      .clk(clk), .rst_n(rst_n), .load(tx_load), .load_val(rd_buf),
      .shift(tx_shift), .msb(tx_msb));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cnt       <= '0;
         rx_sh     <= '0;
         rw        <= 1'b0;
         ack_ok    <= 1'b0;
         rd_pend   <= 1'b0;
         rd_buf    <= '0;
         mem_rd_en <= 1'b0;
         mem_addr  <= '0;
      end else begin
         mem_rd_en <= rd_req;
         if (rd_req) mem_addr <= ctr_q;
         rd_pend <= mem_rd_en;
         if (rd_pend) rd_buf <= mem_rdata;

         if (start_c) begin
            state <= ST_DEVADR;
            cnt   <= '0;
         end else if (stop_c) begin
            state <= ST_IDLE;
            cnt   <= '0;
         end else begin
            unique case (state)
               ST_DEVADR, ST_WORD: begin
                  if (ev_rise) begin
                     rx_sh <= {rx_sh[6:0], sda_s};
                     cnt   <= cnt + 1'b1;
                  end else if (byte_done) begin
                     cnt <= '0;
                     if (state == ST_WORD)  state <= ST_ACK_WORD;
                     else if (addr_hit) begin
                        state <= ST_ACK_DEV;
                        rw    <= rx_sh[0];
                     end else state <= ST_IGNORE;
                  end
               end
               ST_ACK_DEV, ST_ACK_WORD: begin
                  if (ev_rise) cnt <= CNT_W'(1);
                  else if (ev_fall && cnt == CNT_W'(1)) begin
                     cnt <= '0;
                     if (state == ST_ACK_WORD) state <= ST_IGNORE;
                     else state <= rw ? ST_TX : ST_WORD;
                  end
               end
               ST_TX: begin
                  if (ev_rise) cnt <= cnt + 1'b1;
                  else if (byte_done) begin
                     cnt   <= '0;
                     state <= ST_ACK_MST;
                  end
               end
               ST_ACK_MST: begin
                  if (ev_rise) begin
                     cnt    <= CNT_W'(1);
                     ack_ok <= ~sda_s;
                  end else if (ev_fall && cnt == CNT_W'(1)) begin
                     cnt   <= '0;
                     state <= ack_ok ? ST_TX : ST_IGNORE;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_oe = (state == ST_ACK_DEV) || (state == ST_ACK_WORD)
                || ((state == ST_TX) && !tx_msb);
endmodule

// File: rtl/smr_checker.sv
module smr_checker
   import smr_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_s,
   input logic              start_c,
   input smr_state_e        state,
   input logic              sda_oe,
   input logic              mem_rd_en,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [ADDR_W-1:0] ctr_q
);
   // R9: the drive is only taken while the clock line is low
   p_drive_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_s);

   // R10: the line is free in the controller's acknowledge slot
   p_release_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ACK_MST) |-> !sda_oe);

   // R3: an address acknowledge pulls the line low
   p_addr_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ACK_DEV) |-> sda_oe);

   // R8: idle or ignoring means no drive
   p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IGNORE || state == ST_IDLE) |-> !sda_oe);

   // R4 / R7: the counter sits one past every fetched address, wrapping
   p_ctr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |-> (ctr_q == ADDR_W'(mem_addr + 1'b1)));

   // R2: a START always re-arms header reception
   p_start_rearm_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start_c |=> (state == ST_DEVADR));
endmodule

bind i2c_mem_reader smr_checker #(.ADDR_W(ADDR_W)) u_smr_checker (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_c(start_c),
   .state(state), .sda_oe(sda_oe), .mem_rd_en(mem_rd_en),
   .mem_addr(mem_addr), .ctr_q(ctr_q));

// File: tb/i2c_mem_reader_bench.sv
module i2c_mem_reader_bench;
   localparam logic [6:0] DEV = 7'h50;
   localparam int HW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic m_sda = 1'b1;
   logic sda_oe, mem_rd_en;
   logic [7:0] mem_addr, mem_rdata;
   logic sda_line;

   assign sda_line = m_sda & ~sda_oe;
   always #4 clk = ~clk;

   i2c_mem_reader #(.DEV_ADDR(DEV), .ADDR_W(8), .SYNC_STAGES(2)) u_i2c_mem_reader (
      .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
      .sda_oe(sda_oe), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
      .mem_rdata(mem_rdata));

   function automatic logic [7:0] pat(input logic [7:0] a);
      return (a * 8'd37 + 8'h5A) ^ {3'b000, a[7:3]};
   endfunction

   always_ff @(posedge clk) if (mem_rd_en) mem_rdata <= pat(mem_addr);

   int n_chk = 0, n_fail = 0, rd_pulses = 0, glitches = 0;
   logic prev_oe = 1'b0;
   logic [7:0] exp_ctr = 8'd0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_rd_en) rd_pulses++;
         if (scl && (sda_oe != prev_oe)) glitches++;
      end
      prev_oe = sda_oe;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; wt(HW); scl = 1'b1; wt(HW);
      m_sda = 1'b0; wt(HW); scl = 1'b0; wt(HW);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; wt(HW); scl = 1'b1; wt(HW);
      m_sda = 1'b1; wt(HW);
   endtask

   task automatic clk_bit(input logic b, output logic smp, output logic oe);
      m_sda = b; wt(HW); scl = 1'b1; wt(HW);
      smp = sda_line; oe = sda_oe; wt(HW);
      scl = 1'b0; wt(HW);
   endtask

   task automatic send_byte(input logic [7:0] v, output logic acked);
      logic s, o;
      for (int i = 7; i >= 0; i--) clk_bit(v[i], s, o);
      clk_bit(1'b1, s, o);
      acked = ~s;
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] v, output logic oe_ack);
      logic s, o;
      for (int i = 7; i >= 0; i--) begin
         clk_bit(1'b1, s, o);
         v[i] = s;
      end
      clk_bit(give_ack ? 1'b0 : 1'b1, s, o);
      oe_ack = o;
   endtask

   task automatic read_run(input int len, input string req);
      logic [7:0] v;
      logic oe;
      for (int i = 0; i < len; i++) begin
         recv_byte(i != len - 1, v, oe);
         chk(v == pat(exp_ctr), req, v, pat(exp_ctr));
         chk(!oe, "R10 ack slot released", oe, 0);
         exp_ctr = exp_ctr + 8'd1;
      end
   endtask

   task automatic cur_read(input int len, input string req);
      logic a;
      bus_start();
      send_byte({DEV, 1'b1}, a);
      chk(a, "R3 read header ack", a, 1);
      read_run(len, req);
      bus_stop();
   endtask

   task automatic set_addr(input logic [7:0] wa, input bit then_stop);
      logic a;
      bus_start();
      send_byte({DEV, 1'b0}, a);
      chk(a, "R3 write header ack", a, 1);
      send_byte(wa, a);
      chk(a, "R5 byte address ack", a, 1);
      exp_ctr = wa;
      if (then_stop) bus_stop();
   endtask

   task automatic rand_read(input logic [7:0] wa, input int len, input string req);
      logic a;
      set_addr(wa, 1'b0);
      bus_start();
      send_byte({DEV, 1'b1}, a);
      chk(a, "R5 repeated start read header ack", a, 1);
      read_run(len, req);
      bus_stop();
   endtask

   initial begin
      int wd = 0;
      while (wd < 190000) begin @(posedge clk); wd++; end
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic a, s, o;
      int p0;
      void'($urandom(32'h5EED_1234));
      wt(5);
      chk(sda_oe == 1'b0, "R1 reset sda_oe", sda_oe, 0);
      chk(mem_rd_en == 1'b0, "R1 reset mem_rd_en", mem_rd_en, 0);
      rst_n = 1'b1; wt(5);

      cur_read(1, "R1 R4 first read at 0");
      cur_read(2, "R4 R6 current read continues");

      // foreign address: no ack, counter untouched
      bus_start();
      send_byte({7'h51, 1'b1}, a);
      chk(!a, "R3 foreign address not acked", a, 0);
      bus_stop();
      cur_read(1, "R3 counter kept after foreign header");

      rand_read(8'h40, 1, "R5 random read");
      set_addr(8'h9C, 1'b1);
      cur_read(1, "R5 address-only write loads counter");

      // write with data bytes: not acked, counter stays at the address
      set_addr(8'h20, 1'b0);
      send_byte(8'hA5, a);
      chk(!a, "R11 write data not acked", a, 0);
      bus_stop();
      cur_read(1, "R11 counter unchanged by data byte");

      rand_read(8'd254, 4, "R7 wrap 254..1");
      rand_read(8'd250, 258, "R6 R7 long sequential through wrap");

      // NACK then extra clocks: nothing driven, nothing read
      bus_start();
      send_byte({DEV, 1'b1}, a);
      read_run(1, "R8 byte before nack");
      p0 = rd_pulses;
      for (int i = 0; i < 9; i++) begin
         clk_bit(1'b1, s, o);
         chk(s == 1'b1 && !o, "R8 released after nack", o, 0);
      end
      chk(rd_pulses == p0, "R8 no reads after nack", rd_pulses, p0);
      bus_stop();
      cur_read(1, "R8 counter after nack");

      // START in the middle of a header
      bus_start();
      for (int i = 7; i >= 4; i--) clk_bit(DEV[i-1], s, o);
      bus_start();
      send_byte({DEV, 1'b1}, a);
      chk(a, "R2 header after restart acked", a, 1);
      read_run(1, "R2 read after mid-byte START");
      bus_stop();

      for (int it = 0; it < 20; it++) begin
         int op = $urandom % 3;
         int len = 1 + $urandom % 4;
         logic [7:0] wa = 8'($urandom);
         if (op == 0) cur_read(len, "R4 R6 random current read");
         else if (op == 1) rand_read(wa, len, "R5 R6 random selective read");
         else set_addr(wa, 1'b1);
      end
      cur_read(1, "R5 after random mix");

      chk(glitches == 0, "R9 sda_oe stable while clock high", glitches, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule